// File: doc/BRIEF.md
# Segment Address Translation Unit

The unit turns a segment-relative offset into a linear address. It keeps a small file of segment registers. Each register holds a selector, plus a cached base and limit. A protection-enable input chooses between two ways of forming the address.

With protection off, the unit multiplies the selector value by sixteen and adds a 16-bit offset. The result wraps within a 20-bit space, and every load is accepted without any check. With protection on, loading a segment register decodes the selector and reads an 8-byte descriptor from a global descriptor table over a 32-bit memory read port. The load is committed only if the descriptor's privilege level equals the current privilege level. The current privilege level is the low two bits of the code segment register.

After a successful load, every translation through that register takes one cycle and touches no memory. Each translation adds the cached base to the offset and checks the offset against the cached limit. Faults are reported as a 2-bit code: 0 none, 1 limit, 2 privilege, 3 unsupported.

Top module: `seg_xlate_unit`

## Requirements
- R1: With prot_en low, a request on xl_req gives xl_valid on the next cycle. On that cycle xl_addr = (selector*16 + xl_off[15:0]) mod 2^20, bits 31:20 read as zero, xl_off[31:16] is ignored and xl_fault = 0.
- R2: With prot_en low, an accepted load writes any selector value. load_done pulses on the next cycle with load_fault = 0, and no memory read is issued.
- R3: A selector carries the table index in bits 15:3, the local-table flag in bit 2 and the requested level in bits 1:0. The descriptor address is tbl_base + index*8.
- R4: A protected global load performs exactly two 32-bit reads, first at the descriptor address (low word) and then at that address + 4 (high word). mem_rd and mem_addr are held steady until mem_rvalid.
- R5: In a descriptor, the low word is the 32-bit base. In the high word, bits 19:0 are the limit and bits 21:20 are the descriptor privilege level.
- R6: A protected load whose selector has bit 2 set ends on the next cycle with load_fault = 3. It issues no read and leaves the register unchanged.
- R7: The current privilege level is bits 1:0 of segment register CS_IDX (default 0). A protected load commits selector, base and limit only when the level in descriptor bits 21:20 equals it. Otherwise load_fault = 2 and the register is unchanged.
- R8: With prot_en high, a translation gives xl_addr = base + xl_off (mod 2^32) and xl_fault = 0 when xl_off < limit. When xl_off >= limit, it gives xl_addr = 0 and xl_fault = 1. No memory read is made.
- R9: After reset all registers hold selector, base and limit of zero, and load_busy, load_done, xl_valid and mem_rd are low.
- R10: load_req is ignored while load_busy is high; that request modifies no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_en | input | 1 | High selects descriptor-based translation |
| tbl_base | input | 32 | Base address of the global descriptor table |
| load_req | input | 1 | Request to load a segment register |
| load_seg | input | 3 | Segment register to load |
| load_sel | input | 16 | Selector value to load |
| load_busy | output | 1 | Descriptor fetch in progress |
| load_done | output | 1 | One-cycle pulse when a load finishes |
| load_fault | output | 2 | Fault code of the finished load |
| xl_req | input | 1 | Translation request |
| xl_seg | input | 3 | Segment register used for the translation |
| xl_off | input | 32 | Offset within the segment |
| xl_valid | output | 1 | Translation result valid |
| xl_addr | output | 32 | Linear address |
| xl_fault | output | 2 | Fault code of the translation |
| mem_rd | output | 1 | Descriptor read request, held until mem_rvalid |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Compatibility-mode translation is swept over eight selectors crossed with eight offsets. The set includes the all-ones selector and offset, which separates correct 20-bit wrap from carry into bit 20, and offsets with high garbage bits, which shows the upper offset half is discarded. A descriptor sweep loads sixteen table indices whose privilege levels cycle through all four values. It tells a committed load from a refused one by the fault code, the read count and order, and by translations at zero, limit minus one and exactly the limit. The remaining cases each separate one behaviour: a reload of the code segment that changes the current level, a selector with the local flag set, and a second request raised during a fetch.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  localparam int SEL_W = 16;
  localparam int ADR_W = 32;
  localparam int LIM_W = 20;
  localparam int PL_W  = 2;
  localparam int IX_W  = 13;
  localparam int RM_W  = 20;
  localparam int PL_LSB = LIM_W;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_LIMIT = 2'd1,
    FLT_PRIV  = 2'd2,
    FLT_UNSUP = 2'd3
  } seg_fault_e;

  typedef enum logic [1:0] {
    F_IDLE = 2'd0,
    F_LO   = 2'd1,
    F_HI   = 2'd2
  } fetch_state_e;

  function automatic logic [ADR_W-1:0] real_linear(input logic [SEL_W-1:0] sv,
                                                    input logic [15:0] off);
    logic [RM_W-1:0] sum;
    sum = {sv, 4'b0000} + {4'b0000, off};
    return {{(ADR_W-RM_W){1'b0}}, sum};
  endfunction

  function automatic logic [ADR_W-1:0] prot_linear(input logic [ADR_W-1:0] base,
                                                    input logic [ADR_W-1:0] off);
    return base + off;
  endfunction

  function automatic logic within_limit(input logic [ADR_W-1:0] off,
                                        input logic [LIM_W-1:0] lim);
    return off < {{(ADR_W-LIM_W){1'b0}}, lim};
  endfunction

  function automatic logic [ADR_W-1:0] desc_location(input logic [ADR_W-1:0] tbase,
                                                      input logic [IX_W-1:0] idx);
    return tbase + {{(ADR_W-IX_W-3){1'b0}}, idx, 3'b000};
  endfunction

endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_xlate_pkg::*;
(
  input  logic [ADR_W-1:0] tbl_base,
  input  logic [SEL_W-1:0] sel,
  output logic             local_tbl,
  output logic [ADR_W-1:0] desc_addr
);
  logic [IX_W-1:0] index;

  assign index     = sel[SEL_W-1:3];
  assign local_tbl = sel[2];
  assign desc_addr = desc_location(tbl_base, index);
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ADR_W-1:0] start_addr,
  input  logic             mem_rvalid,
  input  logic [ADR_W-1:0] mem_rdata,
  output logic             mem_rd,
  output logic [ADR_W-1:0] mem_addr,
  output logic             busy,
  output logic             hi_done,
  output logic [ADR_W-1:0] lo_word
);
  fetch_state_e     state;
  logic [ADR_W-1:0] addr_q;
  logic [ADR_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= F_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      case (state)
        F_IDLE: if (start) begin
          addr_q <= start_addr;
          state  <= F_LO;
        end
        F_LO: if (mem_rvalid) begin
          lo_q   <= mem_rdata;
          addr_q <= addr_q + ADR_W'(4);
          state  <= F_HI;
        end
        F_HI: if (mem_rvalid) state <= F_IDLE;
        default: state <= F_IDLE;
      endcase
    end
  end

  assign mem_rd   = (state != F_IDLE);
  assign mem_addr = addr_q;
  assign busy     = mem_rd;
  assign hi_done  = (state == F_HI) && mem_rvalid;
  assign lo_word  = lo_q;

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == F_LO && mem_rvalid) |=> (mem_rd && mem_addr == $past(mem_addr) + ADR_W'(4)));

  a_r4_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    hi_done |=> !mem_rd);
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int CS_IDX  = 0,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_full,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [ADR_W-1:0] wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEL_W-1:0] rd_sel,
  output logic [ADR_W-1:0] rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic [SEL_W-1:0] cs_sel
);
  logic [SEL_W-1:0] sel_r  [NUM_SEG];
  logic [ADR_W-1:0] base_r [NUM_SEG];
  logic [LIM_W-1:0] lim_r  [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic [SEL_W-1:0] s_q;
    logic [ADR_W-1:0] b_q;
    logic [LIM_W-1:0] l_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= '0;
        b_q <= '0;
        l_q <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        s_q <= wr_sel;
        if (wr_full) begin
          b_q <= wr_base;
          l_q <= wr_limit;
        end
      end
    end
    assign sel_r[g]  = s_q;
    assign base_r[g] = b_q;
    assign lim_r[g]  = l_q;
  end

  always_comb begin
    rd_sel   = '0;
    rd_base  = '0;
    rd_limit = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_sel   = sel_r[i];
        rd_base  = base_r[i];
        rd_limit = lim_r[i];
      end
    end
  end

  assign cs_sel = sel_r[CS_IDX];
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int CS_IDX  = 0,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prot_en,
  input  logic [31:0]      tbl_base,
  input  logic             load_req,
  input  logic [IDX_W-1:0] load_seg,
  input  logic [15:0]      load_sel,
  output logic             load_busy,
  output logic             load_done,
  output logic [1:0]       load_fault,
  input  logic             xl_req,
  input  logic [IDX_W-1:0] xl_seg,
  input  logic [31:0]      xl_off,
  output logic             xl_valid,
  output logic [31:0]      xl_addr,
  output logic [1:0]       xl_fault,
  output logic             mem_rd,
  output logic [31:0]      mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);
  logic             load_fire;
  logic             sel_local;
  logic [ADR_W-1:0] sel_daddr;
  logic             fetch_start;
  logic             fetch_busy;
  logic             hi_done;
  logic [ADR_W-1:0] lo_word;
  logic [IDX_W-1:0] pend_seg;
  logic [SEL_W-1:0] pend_sel;
  logic [PL_W-1:0]  cpl;
  logic [PL_W-1:0]  desc_dpl;
  logic [LIM_W-1:0] desc_limit;
  logic             priv_ok;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [SEL_W-1:0] wr_sel;
  logic [SEL_W-1:0] rd_sel;
  logic [ADR_W-1:0] rd_base;
  logic [LIM_W-1:0] rd_limit;
  logic [SEL_W-1:0] cs_sel;
  logic             done_q;
  logic [1:0]       lfault_q;
  logic             xv_q;
  logic [ADR_W-1:0] xa_q;
  logic [1:0]       xf_q;
  logic             unused_hi;

  assign load_busy   = fetch_busy;
  assign load_fire   = load_req && !fetch_busy;
  assign fetch_start = load_fire && prot_en && !sel_local;

  seg_sel_decode u_dec (
    .tbl_base (tbl_base),
    .sel      (load_sel),
    .local_tbl(sel_local),
    .desc_addr(sel_daddr)
  );

  seg_desc_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fetch_start),
    .start_addr(sel_daddr),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .busy      (fetch_busy),
    .hi_done   (hi_done),
    .lo_word   (lo_word)
  );

  assign desc_limit = mem_rdata[LIM_W-1:0];
  assign desc_dpl   = mem_rdata[PL_LSB +: PL_W];
  assign unused_hi  = ^mem_rdata[ADR_W-1:PL_LSB+PL_W];
  assign cpl        = cs_sel[PL_W-1:0];
  assign priv_ok    = (desc_dpl == cpl);

  assign wr_en  = (load_fire && !prot_en) || (hi_done && priv_ok);
  assign wr_idx = hi_done ? pend_seg : load_seg;
  assign wr_sel = hi_done ? pend_sel : load_sel;

  seg_cache #(.NUM_SEG(NUM_SEG), .CS_IDX(CS_IDX), .IDX_W(IDX_W)) u_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_full (hi_done),
    .wr_idx  (wr_idx),
    .wr_sel  (wr_sel),
    .wr_base (lo_word),
    .wr_limit(desc_limit),
    .rd_idx  (xl_seg),
    .rd_sel  (rd_sel),
    .rd_base (rd_base),
    .rd_limit(rd_limit),
    .cs_sel  (cs_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_seg <= '0;
      pend_sel <= '0;
      done_q   <= 1'b0;
      lfault_q <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      if (load_fire) begin
        pend_seg <= load_seg;
        pend_sel <= load_sel;
        if (!prot_en || sel_local) begin
          done_q   <= 1'b1;
          lfault_q <= prot_en ? FLT_UNSUP : FLT_NONE;
        end
      end else if (hi_done) begin
        done_q   <= 1'b1;
        lfault_q <= priv_ok ? FLT_NONE : FLT_PRIV;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xv_q <= 1'b0;
      xa_q <= '0;
      xf_q <= FLT_NONE;
    end else begin
      xv_q <= xl_req;
      if (xl_req) begin
        if (!prot_en) begin
          xa_q <= real_linear(rd_sel, xl_off[15:0]);
          xf_q <= FLT_NONE;
        end else if (within_limit(xl_off, rd_limit)) begin
          xa_q <= prot_linear(rd_base, xl_off);
          xf_q <= FLT_NONE;
        end else begin
          xa_q <= '0;
          xf_q <= FLT_LIMIT;
        end
      end
    end
  end

  assign load_done  = done_q;
  assign load_fault = lfault_q;
  assign xl_valid   = xv_q;
  assign xl_addr    = xa_q;
  assign xl_fault   = xf_q;

  a_r2_real_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && !prot_en) |=> (load_done && load_fault == FLT_NONE && !mem_rd));

  a_r6_local_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && prot_en && load_sel[2]) |=> (load_done && load_fault == FLT_UNSUP && !mem_rd));

  a_r3_desc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && prot_en && !load_sel[2]) |=>
      (mem_rd && mem_addr == $past(tbl_base) + {16'b0, $past(load_sel[15:3]), 3'b000}));

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid);

  a_r1_real_range: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && !prot_en) |=> (xl_fault == FLT_NONE && xl_addr[31:20] == 12'h000));

  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && load_busy && !hi_done) |=> !load_done);
endmodule

// File: tb/seg_xlate_unit_test.sv
`timescale 1ns/1ps
module seg_xlate_unit_test;
  localparam logic [31:0] GDT = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_en = 1'b0;
  logic [31:0] tbl_base = GDT;
  logic        load_req = 1'b0;
  logic [2:0]  load_seg = '0;
  logic [15:0] load_sel = '0;
  logic        load_busy, load_done;
  logic [1:0]  load_fault;
  logic        xl_req = 1'b0;
  logic [2:0]  xl_seg = '0;
  logic [31:0] xl_off = '0;
  logic        xl_valid;
  logic [31:0] xl_addr;
  logic [1:0]  xl_fault;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int rd_count = 0;
  logic [31:0] rd_log [0:7];
  logic [31:0] exp_base [0:5];
  logic [19:0] exp_lim  [0:5];

  always #4 clk = ~clk;

  seg_xlate_unit uut (
    .clk(clk), .rst_n(rst_n), .prot_en(prot_en), .tbl_base(tbl_base),
    .load_req(load_req), .load_seg(load_seg), .load_sel(load_sel),
    .load_busy(load_busy), .load_done(load_done), .load_fault(load_fault),
    .xl_req(xl_req), .xl_seg(xl_seg), .xl_off(xl_off),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_fault(xl_fault),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] d_base(input int idx);
    return 32'h1000_0000 + 32'(idx) * 32'h0101_0010;
  endfunction
  function automatic logic [19:0] d_lim(input int idx);
    return 20'h00100 + 20'(idx * 16);
  endfunction
  function automatic logic [1:0] d_dpl(input int idx);
    return 2'(idx % 4);
  endfunction
  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] rel;
    int idx;
    rel = a - GDT;
    idx = int'(rel >> 3);
    if (rel[2]) return {10'b0, d_dpl(idx), d_lim(idx)};
    return d_base(idx);
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_rd && !mem_rvalid;
    if (mem_rd && !mem_rvalid) begin
      mem_rdata <= word_at(mem_addr);
      rd_log[rd_count % 8] <= mem_addr;
      rd_count <= rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [2:0] seg, input logic [15:0] sel,
                         output logic [1:0] flt, output int nreads, output bit got);
    int c0;
    c0 = rd_count;
    got = 1'b0;
    flt = 2'b00;
    @(negedge clk);
    load_req = 1'b1; load_seg = seg; load_sel = sel;
    @(negedge clk);
    load_req = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (load_done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    flt = load_fault;
    nreads = rd_count - c0;
    @(negedge clk);
  endtask

  task automatic do_xl(input logic [2:0] seg, input logic [31:0] off,
                       output logic v, output logic [31:0] a, output logic [1:0] f);
    @(negedge clk);
    xl_req = 1'b1; xl_seg = seg; xl_off = off;
    @(negedge clk);
    xl_req = 1'b0;
    v = xl_valid; a = xl_addr; f = xl_fault;
  endtask

  task automatic chk_prot_xl(input logic [2:0] seg, input string req);
    logic v; logic [31:0] a; logic [1:0] f;
    logic [31:0] lim32;
    lim32 = {12'b0, exp_lim[seg]};
    do_xl(seg, 32'h0, v, a, f);
    if (exp_lim[seg] == 20'h0)
      chk(v && f == 2'd1 && a == 32'h0, req, {f, a[29:0]}, 32'h4000_0000);
    else
      chk(v && f == 2'd0 && a == exp_base[seg], req, a, exp_base[seg]);
    if (exp_lim[seg] != 20'h0) begin
      do_xl(seg, lim32 - 1, v, a, f);
      chk(v && f == 2'd0 && a == exp_base[seg] + lim32 - 1, req, a, exp_base[seg] + lim32 - 1);
      do_xl(seg, lim32, v, a, f);
      chk(v && f == 2'd1 && a == 32'h0, req, {30'b0, f}, 32'd1);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [1:0] flt; int nr; bit got;
    logic v; logic [31:0] a; logic [1:0] f;
    logic [15:0] sels [0:7];
    logic [31:0] offs [0:7];
    sels[0] = 16'h0000; sels[1] = 16'h0001; sels[2] = 16'h1234; sels[3] = 16'h8000;
    sels[4] = 16'hF000; sels[5] = 16'hFFFF; sels[6] = 16'h0FFF; sels[7] = 16'hA5A5;
    offs[0] = 32'h0000_0000; offs[1] = 32'hDEAD_0001; offs[2] = 32'h0000_000F; offs[3] = 32'hDEAD_0010;
    offs[4] = 32'h0000_7FFF; offs[5] = 32'hDEAD_8000; offs[6] = 32'h0000_FFF0; offs[7] = 32'hDEAD_FFFF;
    for (int i = 0; i < 6; i++) begin exp_base[i] = '0; exp_lim[i] = '0; end

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!load_busy && !load_done && !xl_valid && !mem_rd, "R9 idle outputs",
        {28'b0, load_busy, load_done, xl_valid, mem_rd}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    do_xl(3'd2, 32'h0000_1234, v, a, f);
    chk(v && a == 32'h0000_1234 && f == 2'd0, "R9 zero selector after reset", a, 32'h0000_1234);

    // R1, R2: compatibility-mode sweep
    for (int s = 0; s < 8; s++) begin
      do_load(3'd1, sels[s], flt, nr, got);
      chk(got && flt == 2'd0 && nr == 0, "R2 real load accepted, no reads",
          {got, 15'b0, 14'b0, flt}, 32'h8000_0000);
      for (int o = 0; o < 8; o++) begin
        logic [31:0] e;
        e = ({12'b0, sels[s], 4'b0} + {16'b0, offs[o][15:0]}) & 32'h000F_FFFF;
        do_xl(3'd1, offs[o], v, a, f);
        chk(v && a == e && f == 2'd0, "R1 shift-add translation", a, e);
      end
    end
    // code segment gets level 3 in compatibility mode
    do_load(3'd0, 16'h0003, flt, nr, got);
    chk(got && flt == 2'd0 && nr == 0, "R2 code segment load", {30'b0, flt}, 32'h0);

    prot_en = 1'b1;
    // R6: local-table selector
    do_load(3'd2, {13'd5, 1'b1, 2'b11}, flt, nr, got);
    chk(got && flt == 2'd3, "R6 local flag fault code", {30'b0, flt}, 32'd3);
    chk(nr == 0, "R6 no memory read", nr, 32'd0);
    do_xl(3'd2, 32'h0, v, a, f);
    chk(v && f == 2'd1, "R6 register unchanged (limit still zero)", {30'b0, f}, 32'd1);

    // R3, R4, R5, R7, R8: descriptor sweep at level 3
    for (int idx = 0; idx < 16; idx++) begin
      logic [15:0] sel;
      logic [31:0] da;
      bit ok;
      sel = {13'(idx), 1'b0, 2'(idx % 4)};
      da = GDT + 32'(idx) * 8;
      ok = (d_dpl(idx) == 2'd3);
      do_load(3'd3, sel, flt, nr, got);
      chk(got && flt == (ok ? 2'd0 : 2'd2), "R7 privilege compare", {30'b0, flt}, ok ? 32'd0 : 32'd2);
      chk(nr == 2, "R4 two reads per descriptor", nr, 32'd2);
      chk(rd_log[(rd_count - 2) % 8] == da, "R3 low word address", rd_log[(rd_count - 2) % 8], da);
      chk(rd_log[(rd_count - 1) % 8] == da + 4, "R4 high word second", rd_log[(rd_count - 1) % 8], da + 4);
      if (ok) begin exp_base[3] = d_base(idx); exp_lim[3] = d_lim(idx); end
      nr = rd_count;
      chk_prot_xl(3'd3, "R5 R8 base/limit from descriptor");
      chk(rd_count == nr, "R8 translation makes no read", rd_count - nr, 32'd0);
    end

    // R7: code segment reload changes the level (idx 7 has level 3, rpl 0 -> level 0)
    do_load(3'd0, {13'd7, 1'b0, 2'b00}, flt, nr, got);
    chk(got && flt == 2'd0, "R7 code segment reload", {30'b0, flt}, 32'd0);
    do_load(3'd3, {13'd5, 1'b0, 2'b00}, flt, nr, got);
    chk(got && flt == 2'd2, "R7 level-1 descriptor refused at level 0", {30'b0, flt}, 32'd2);
    chk_prot_xl(3'd3, "R7 refused load keeps register");
    do_load(3'd3, {13'd4, 1'b0, 2'b11}, flt, nr, got);
    chk(got && flt == 2'd0, "R7 level-0 descriptor accepted at level 0", {30'b0, flt}, 32'd0);
    exp_base[3] = d_base(4); exp_lim[3] = d_lim(4);
    chk_prot_xl(3'd3, "R8 after level change");

    // R10: second request while busy is ignored
    nr = rd_count;
    @(negedge clk);
    load_req = 1'b1; load_seg = 3'd4; load_sel = {13'd8, 1'b0, 2'b00};
    @(negedge clk);
    load_seg = 3'd5; load_sel = {13'd12, 1'b0, 2'b00};
    @(negedge clk);
    load_req = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (load_done) begin got = 1'b1; break; end
      @(negedge clk);
    end
    flt = load_fault;
    chk(got && flt == 2'd0, "R10 first load completes", {30'b0, flt}, 32'd0);
    repeat (4) @(negedge clk);
    chk(rd_count - nr == 2, "R10 only one fetch", rd_count - nr, 32'd2);
    exp_base[4] = d_base(8); exp_lim[4] = d_lim(8);
    chk_prot_xl(3'd4, "R10 first target loaded");
    chk_prot_xl(3'd5, "R10 ignored target untouched");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule